// File: doc/BRIEF.md
# Interval Phase Classifier

This block watches a single processor core over fixed-length windows of execution and sorts each finished window into one of three classes: the core is running short of resources (upgrade), it is leaving resources idle (downgrade), or neither (no-change). A scheduler further along uses the class stream to decide when to move work between cores of different strength. The block does not make that decision itself.

Every clock cycle the block takes three numbers from the core: how many instructions retired, how many integer instruction-window entries are occupied, and how many floating-point instruction-window entries are occupied. It keeps a running sum of each. On the last cycle of a window it folds in that cycle's values and compares the sums against four threshold inputs. It then emits a one-cycle strobe with a 2-bit class code and restarts all sums from zero.

The utilization thresholds are raw occupancy-sum values. Software precomputes them as a fraction of window size times window length, so no divider is needed in hardware. The throughput thresholds are raw retired-instruction counts.

Top module: `phase_classifier`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cls_valid` is 0 and `cls_code` is 00.
- R2: `cls_valid` pulses high for exactly one cycle once per window of `INTERVAL_CYCLES` sampled cycles. The first pulse is visible in the cycle after the `INTERVAL_CYCLES`-th rising edge at which `rst` is low. Later pulses are exactly `INTERVAL_CYCLES` cycles apart.
- R3: The throughput figure of a window is the sum of `retire_cnt` over every one of its cycles, including the final one. All sums start again from zero for the next window, so one window's inputs never affect another window's class.
- R4: The utilization figure of a window is the larger of the integer occupancy sum and the floating-point occupancy sum.
- R5: The class is upgrade (code 01) when utilization is strictly greater than `thr_util_hi` or throughput is strictly greater than `thr_tput_hi`.
- R6: The class is downgrade (code 10) only when utilization is strictly less than `thr_util_lo` and throughput is strictly less than `thr_tput_lo`.
- R7: Every other window is no-change (code 00), including windows where a figure exactly equals a threshold. Code 11 never appears.
- R8: When a window meets both the upgrade and the downgrade condition, the class is upgrade.
- R9: `cls_code` keeps the class of the most recent window until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_cnt | input | RETIRE_W | Instructions retired this cycle |
| int_occ | input | INT_OCC_W | Occupied integer window entries this cycle |
| fp_occ | input | FP_OCC_W | Occupied floating-point window entries this cycle |
| thr_tput_hi | input | TPUT_W | Throughput above which a window is upgrade |
| thr_tput_lo | input | TPUT_W | Throughput below which a window may be downgrade |
| thr_util_hi | input | UTIL_W | Occupancy sum above which a window is upgrade |
| thr_util_lo | input | UTIL_W | Occupancy sum below which a window may be downgrade |
| cls_valid | output | 1 | One-cycle strobe at the end of each window |
| cls_code | output | 2 | Class: 00 no-change, 01 upgrade, 10 downgrade |

## Verification
The bench aims at threshold equality, where a design comparing with >= or <= would report upgrade or downgrade instead of no-change. It also aims at windows where the floating-point sum exceeds the integer sum, which a design reading only one accumulator would misclassify. Two further cases are windows that meet both conditions, where a wrong priority yields downgrade, and an all-zero window that follows a busy one, which only reads as downgrade if the sums were really cleared and the final cycle's values were counted in the right window. Strobe spacing and code hold are checked on every cycle of every window, so an off-by-one window length or a code that changes between strobes is reported.

// File: rtl/pc_pkg.sv
package pc_pkg;
   typedef enum logic [1:0] {
      PC_NOCHANGE  = 2'b00,
      PC_UPGRADE   = 2'b01,
      PC_DOWNGRADE = 2'b10
   } pc_class_e;
endpackage

// File: rtl/pc_timer.sv
module pc_timer #(
   parameter int unsigned LEN = 100000
) (
   input  logic clk,
   input  logic rst,
   output logic last
);
   localparam int unsigned CW = (LEN > 2) ? $clog2(LEN) : 1;

   logic [CW-1:0] cnt;

   assign last = (cnt == CW'(LEN - 1));

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (last) cnt <= '0;
      else           cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/pc_accum.sv
module pc_accum #(
   parameter int unsigned IN_W  = 3,
   parameter int unsigned ACC_W = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic [IN_W-1:0]  inc,
   output logic [ACC_W-1:0] sum_next
);
   logic [ACC_W-1:0] acc;

   always_comb sum_next = acc + ACC_W'(inc);

   always_ff @(posedge clk) begin
      if (rst)      acc <= '0;
      else if (clr) acc <= '0;
      else          acc <= sum_next;
   end
endmodule

// File: rtl/pc_decide.sv
module pc_decide
   import pc_pkg::*;
#(
   parameter int unsigned TPUT_W = 20,
   parameter int unsigned UTIL_W = 24
) (
   input  logic [TPUT_W-1:0] tput,
   input  logic [UTIL_W-1:0] util_a,
   input  logic [UTIL_W-1:0] util_b,
   input  logic [TPUT_W-1:0] tput_hi,
   input  logic [TPUT_W-1:0] tput_lo,
   input  logic [UTIL_W-1:0] util_hi,
   input  logic [UTIL_W-1:0] util_lo,
   output pc_class_e         cls
);
   logic [UTIL_W-1:0] util;
   logic              want_up, want_down;

   always_comb begin
      util      = (util_a > util_b) ? util_a : util_b;
      want_up   = (util > util_hi) || (tput > tput_hi);
      want_down = (util < util_lo) && (tput < tput_lo);
      if (want_up)        cls = PC_UPGRADE;
      else if (want_down) cls = PC_DOWNGRADE;
      else                cls = PC_NOCHANGE;
   end
endmodule

// File: rtl/phase_classifier.sv
module phase_classifier
   import pc_pkg::*;
#(
   parameter int unsigned INTERVAL_CYCLES = 100000,
   parameter int unsigned RETIRE_W        = 3,
   parameter int unsigned INT_OCC_W       = 7,
   parameter int unsigned FP_OCC_W        = 6,
   parameter int unsigned TPUT_W          = 20,
   parameter int unsigned INT_ACC_W       = 24,
   parameter int unsigned FP_ACC_W        = 23,
   localparam int unsigned UTIL_W = (INT_ACC_W > FP_ACC_W) ? INT_ACC_W : FP_ACC_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [RETIRE_W-1:0]  retire_cnt,
   input  logic [INT_OCC_W-1:0] int_occ,
   input  logic [FP_OCC_W-1:0]  fp_occ,
   input  logic [TPUT_W-1:0]    thr_tput_hi,
   input  logic [TPUT_W-1:0]    thr_tput_lo,
   input  logic [UTIL_W-1:0]    thr_util_hi,
   input  logic [UTIL_W-1:0]    thr_util_lo,
   output logic                 cls_valid,
   output logic [1:0]           cls_code
);
   localparam longint MAX_TPUT = longint'((2 ** RETIRE_W) - 1) * longint'(INTERVAL_CYCLES);
   localparam longint MAX_INT  = longint'((2 ** INT_OCC_W) - 1) * longint'(INTERVAL_CYCLES);
   localparam longint MAX_FP   = longint'((2 ** FP_OCC_W) - 1) * longint'(INTERVAL_CYCLES);

   generate
      if (INTERVAL_CYCLES < 2)
         $error("phase_classifier: INTERVAL_CYCLES must be at least 2");
      if (MAX_TPUT >= (longint'(1) << TPUT_W))
         $error("phase_classifier: TPUT_W too narrow for one window");
      if (MAX_INT >= (longint'(1) << INT_ACC_W))
         $error("phase_classifier: INT_ACC_W too narrow for one window");
      if (MAX_FP >= (longint'(1) << FP_ACC_W))
         $error("phase_classifier: FP_ACC_W too narrow for one window");
   endgenerate

   logic                 win_last;
   logic [TPUT_W-1:0]    tput_sum;
   logic [INT_ACC_W-1:0] int_sum;
   logic [FP_ACC_W-1:0]  fp_sum;
   pc_class_e            cls_now;

   pc_timer #(.LEN(INTERVAL_CYCLES)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .last (win_last)
   );

   pc_accum #(.IN_W(RETIRE_W), .ACC_W(TPUT_W)) u_acc_tput (
      .clk (clk), .rst (rst), .clr (win_last), .inc (retire_cnt), .sum_next (tput_sum)
   );

   pc_accum #(.IN_W(INT_OCC_W), .ACC_W(INT_ACC_W)) u_acc_int (
      .clk (clk), .rst (rst), .clr (win_last), .inc (int_occ), .sum_next (int_sum)
   );

   pc_accum #(.IN_W(FP_OCC_W), .ACC_W(FP_ACC_W)) u_acc_fp (
      .clk (clk), .rst (rst), .clr (win_last), .inc (fp_occ), .sum_next (fp_sum)
   );

   pc_decide #(.TPUT_W(TPUT_W), .UTIL_W(UTIL_W)) u_decide (
      .tput    (tput_sum),
      .util_a  (UTIL_W'(int_sum)),
      .util_b  (UTIL_W'(fp_sum)),
      .tput_hi (thr_tput_hi),
      .tput_lo (thr_tput_lo),
      .util_hi (thr_util_hi),
      .util_lo (thr_util_lo),
      .cls     (cls_now)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cls_valid <= 1'b0;
         cls_code  <= PC_NOCHANGE;
      end else begin
         cls_valid <= win_last;
         if (win_last) cls_code <= cls_now;
      end
   end
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
   parameter int unsigned INTERVAL_CYCLES = 100000
) (
   input logic       clk,
   input logic       rst,
   input logic       cls_valid,
   input logic [1:0] cls_code
);
   localparam int unsigned GW = $clog2(INTERVAL_CYCLES + 1) + 1;

   logic [GW-1:0] gap;

   always_ff @(posedge clk) begin
      if (rst)            gap <= '0;
      else if (cls_valid) gap <= GW'(1);
      else                gap <= gap + GW'(1);
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (!cls_valid && cls_code == 2'b00));

   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      cls_valid |=> !cls_valid);

   assert_pulse_spacing_R2: assert property (@(posedge clk) disable iff (rst)
      cls_valid == (gap == GW'(INTERVAL_CYCLES)));

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
      gap <= GW'(INTERVAL_CYCLES));

   assert_legal_code_R7: assert property (@(posedge clk) disable iff (rst)
      cls_code != 2'b11);

   assert_code_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !cls_valid |-> $stable(cls_code));
endmodule

bind phase_classifier pc_checker #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) i_pc_checker (
   .clk       (clk),
   .rst       (rst),
   .cls_valid (cls_valid),
   .cls_code  (cls_code)
);

// File: tb/test_phase_classifier.sv
`timescale 1ns/1ps
module test_phase_classifier;
   localparam int N      = 16;
   localparam int TPUT_W = 20;
   localparam int UTIL_W = 24;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [2:0]        retire_cnt = '0;
   logic [6:0]        int_occ = '0;
   logic [5:0]        fp_occ = '0;
   logic [TPUT_W-1:0] thr_tput_hi = '0, thr_tput_lo = '0;
   logic [UTIL_W-1:0] thr_util_hi = '0, thr_util_lo = '0;
   logic              cls_valid;
   logic [1:0]        cls_code;

   int checks = 0;
   int errors = 0;
   bit done   = 0;
   int prev_code = 0;

   always #2 clk = ~clk;

   phase_classifier #(.INTERVAL_CYCLES(N)) i_phase_classifier (
      .clk, .rst, .retire_cnt, .int_occ, .fp_occ,
      .thr_tput_hi, .thr_tput_lo, .thr_util_hi, .thr_util_lo,
      .cls_valid, .cls_code
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int expect_class(int t, int ui, int uf, int th, int tl, int uh, int ul);
      int u;
      u = (ui > uf) ? ui : uf;
      if (u > uh || t > th) return 1;
      if (u < ul && t < tl) return 2;
      return 0;
   endfunction

   task automatic set_thr(int th, int tl, int uh, int ul);
      thr_tput_hi = TPUT_W'(th);
      thr_tput_lo = TPUT_W'(tl);
      thr_util_hi = UTIL_W'(uh);
      thr_util_lo = UTIL_W'(ul);
   endtask

   // Called at a negedge; drives N cycles, then checks the strobe and class.
   task automatic run_window(string req, bit rnd, int r, int iv, int fv);
      int st = 0, si = 0, sf = 0, e;
      for (int i = 0; i < N; i++) begin
         if (rnd) begin
            r  = $urandom % 7;
            iv = $urandom % 105;
            fv = $urandom % 49;
         end
         retire_cnt = 3'(r);
         int_occ    = 7'(iv);
         fp_occ     = 6'(fv);
         st += r; si += iv; sf += fv;
         if (i > 0) begin
            chk("R2 strobe low inside window", int'(cls_valid), 0);
            chk("R9 code held between strobes", int'(cls_code), prev_code);
         end
         @(negedge clk);
      end
      e = expect_class(st, si, sf, int'(thr_tput_hi), int'(thr_tput_lo),
                       int'(thr_util_hi), int'(thr_util_lo));
      chk("R2 strobe at window end", int'(cls_valid), 1);
      chk(req, int'(cls_code), e);
      prev_code = e;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1337));
      repeat (4) @(negedge clk);
      chk("R1 valid in reset", int'(cls_valid), 0);
      chk("R1 code in reset", int'(cls_code), 0);
      rst = 1'b0;
      chk("R1 valid after reset", int'(cls_valid), 0);

      // R6: idle window, strict lows of 1
      set_thr(1000, 1, 5000, 1);
      run_window("R6 idle downgrade", 0, 0, 0, 0);
      // R7: throughput 32 equals high threshold -> no-change
      set_thr(32, 10, 5000, 1);
      run_window("R7 equal tput high", 0, 2, 0, 0);
      // R5: throughput 32 above 31 -> upgrade
      set_thr(31, 10, 5000, 1);
      run_window("R5 tput above high", 0, 2, 0, 0);
      // R5: integer sum 800 above 799 -> upgrade
      set_thr(1000, 1, 799, 1);
      run_window("R5 util above high", 0, 0, 50, 10);
      // R4: fp sum 640 dominates integer 80; above 600 -> upgrade
      set_thr(1000, 1, 600, 1);
      run_window("R4 fp sum is utilization", 0, 0, 5, 40);
      // R4/R6: fp 640 below 650 -> downgrade
      set_thr(1000, 1, 700, 650);
      run_window("R4 fp sum downgrade", 0, 0, 5, 40);
      // R6/R7: utilization equals low threshold -> no-change
      set_thr(1000, 1, 700, 640);
      run_window("R7 equal util low", 0, 0, 5, 40);
      // R8: both conditions true -> upgrade wins
      set_thr(1000, 1, 100, 1000);
      run_window("R8 upgrade priority", 0, 0, 31, 0);
      // R3: heavy window then idle window must read as cleared
      set_thr(1000, 1, 5000, 1);
      run_window("R3 heavy window", 0, 6, 104, 48);
      run_window("R3 sums cleared", 0, 0, 0, 0);

      for (int k = 0; k < 24; k++) begin
         set_thr($urandom % 120, $urandom % 120, $urandom % 1700, $urandom % 1700);
         run_window("R5 R6 R7 random window", 1, 0, 0, 0);
      end

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule